// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Bus

This block collects up to 32 interrupt request lines and merges them into a single request to a processor. Each line is sensed either as a level or as a rising edge. The choice is made per line by a mask parameter that is fixed at elaboration. Captured requests are held in a status register and filtered by an enable register. The lowest-numbered request that survives the filter is reported as a vector, so the handler can branch straight to it.

Software reaches the block over a word-indexed 32-bit register port with separate read and write strobes. Single-write alias registers are provided for three operations: acknowledging status bits, setting enable bits and clearing enable bits. A two-bit control register gates the processor request and the hardware capture independently. While hardware capture is off, software may load the status register directly, which lets the whole path be exercised with no external stimulus.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the status, enable and control registers read zero, the vector reads 0xFFFFFFFF and `irq_out` is low.
- R2: The registers are selected by word index: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 control. Reads of indices 3, 4, 5 and of any index from 8 up return zero. Writes to indices 1, 6 and 8 and up change nothing.
- R3: A write to index 3 clears each status bit whose write-data bit is 1 and leaves the other status bits alone.
- R4: A write to index 4 ORs the write data into the enable register.
- R5: A write to index 5 clears each enable bit whose write-data bit is 1.
- R6: The control register stores only write-data bits [1:0] and reads back zero above them. Bit 0 gates `irq_out`. Bit 1 enables hardware capture.
- R7: A write to index 0 loads the status register when control bit 1 is clear. The write is ignored when control bit 1 is set.
- R8: While control bit 1 is set, a level-sensed line (mask bit 0) that is high sets its status bit on every cycle, so an acknowledge does not clear it while the line stays high. Lines pass two synchronizer flops, so status follows a line change on the third rising clock edge.
- R9: An edge-sensed line (mask bit 1) sets its status bit once per rising edge, with the same three-edge latency, and only while control bit 1 is set. A line held high does not set the bit again after an acknowledge. An edge seen while capture is off is lost.
- R10: Index 1 reads the bitwise AND of status and enable.
- R11: Index 6 reads the number of the lowest set pending bit, or 0xFFFFFFFF when no bit is pending.
- R12: `irq_out` is high exactly when control bit 0 is set and at least one pending bit is set. It follows register changes in the cycle after the write.
- R13: `reg_rdata` is registered. It shows the selected register on the clock edge that samples `reg_rd`, and it already reflects a write accepted on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears all state |
| reg_addr | input | 4 | Word index of the register accessed |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| src_in | input | 32 | Interrupt request lines, asynchronous |
| irq_out | output | 1 | Combined interrupt request to the processor |

## Verification
A wrong status, enable or control bit shows on `irq_out` and on the vector in the cycle after the write that caused it. It also shows on the next read of the status, pending or vector index, one edge after the read strobe. A fault in capture shows three edges after a line changes, either as a request that never appears or as one that returns after an acknowledge. Line stimulus is therefore checked at that distance, with both sensing types and with capture both on and off.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

   // Word indices of the register map; order is decoded by software
   typedef enum logic [2:0] {
      REG_STATUS = 3'd0,
      REG_PEND   = 3'd1,
      REG_ENA    = 3'd2,
      REG_ACK    = 3'd3,
      REG_SETEN  = 3'd4,
      REG_CLREN  = 3'd5,
      REG_VEC    = 3'd6,
      REG_CTRL   = 3'd7
   } ivc_reg_e;

   localparam int CTRL_W      = 2;
   localparam int CTRL_OUT_EN = 0;
   localparam int CTRL_CAP_EN = 1;
   localparam int MAP_IDX_W   = 3;

endpackage

// File: rtl/ivc_input_cond.sv
module ivc_input_cond #(
   parameter int            NSRC        = 32,
   parameter logic [NSRC-1:0] EDGE_MASK = '0,
   parameter int            SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_in,
   output logic [NSRC-1:0] hit
);

   localparam int LAST = SYNC_STAGES - 1;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic [SYNC_STAGES-1:0] sync_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], src_in[i]};
      end

      if (EDGE_MASK[i]) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= sync_q[LAST];
         end
         assign hit[i] = sync_q[LAST] & ~prev_q;
      end else begin : g_level
         assign hit[i] = sync_q[LAST];
      end
   end

endmodule

// File: rtl/ivc_regs.sv
module ivc_regs
   import ivc_pkg::*;
#(
   parameter int NSRC = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  ivc_reg_e          wr_idx,
   input  logic [NSRC-1:0]   wr_bits,
   input  logic [CTRL_W-1:0] wr_ctrl,
   input  logic [NSRC-1:0]   hit,
   output logic [NSRC-1:0]   status_q,
   output logic [NSRC-1:0]   enable_q,
   output logic [CTRL_W-1:0] ctrl_q
);

   logic [NSRC-1:0]   status_d;
   logic [NSRC-1:0]   enable_d;
   logic [CTRL_W-1:0] ctrl_d;
   logic              cap_on;

   assign cap_on = ctrl_q[CTRL_CAP_EN];

   always_comb begin
      status_d = status_q;
      enable_d = enable_q;
      ctrl_d   = ctrl_q;
      if (wr_en) begin
         unique case (wr_idx)
            REG_STATUS: if (!cap_on) status_d = wr_bits;
            REG_ACK:    status_d = status_q & ~wr_bits;
            REG_ENA:    enable_d = wr_bits;
            REG_SETEN:  enable_d = enable_q | wr_bits;
            REG_CLREN:  enable_d = enable_q & ~wr_bits;
            REG_CTRL:   ctrl_d   = wr_ctrl;
            default:    ;
         endcase
      end
      // hardware capture is applied after the software operation
      if (cap_on) status_d = status_d | hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         enable_q <= '0;
         ctrl_q   <= '0;
      end else begin
         status_q <= status_d;
         enable_q <= enable_d;
         ctrl_q   <= ctrl_d;
      end
   end

endmodule

// File: rtl/ivc_lowest.sv
module ivc_lowest #(
   parameter int N  = 32,
   parameter int DW = 32
) (
   input  logic [N-1:0]  vec,
   output logic          found,
   output logic [DW-1:0] idx
);

   always_comb begin
      found = 1'b0;
      idx   = '1;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = DW'(i);
         end
      end
   end

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
   import ivc_pkg::*;
#(
   parameter int              NSRC        = 32,
   parameter int              DW          = 32,
   parameter int              ADDR_W      = 4,
   parameter int              SYNC_STAGES = 2,
   parameter logic [NSRC-1:0] EDGE_MASK   = 32'hFFFF_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   input  logic [NSRC-1:0]   src_in,
   output logic              irq_out
);

   localparam int HI_W = ADDR_W - MAP_IDX_W;

   if (NSRC < 2 || NSRC > DW) begin : g_bad_nsrc
      $error("irq_vec_ctrl: NSRC must lie in 2..DW");
   end
   if (ADDR_W < MAP_IDX_W) begin : g_bad_addr
      $error("irq_vec_ctrl: ADDR_W must cover the eight-word map");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_vec_ctrl: SYNC_STAGES must be at least 2");
   end

   logic              in_map;
   ivc_reg_e          idx;
   logic [NSRC-1:0]   hit_w;
   logic [NSRC-1:0]   status_w;
   logic [NSRC-1:0]   enable_w;
   logic [CTRL_W-1:0] ctrl_w;
   logic [NSRC-1:0]   pend_w;
   logic              any_pend;
   logic [DW-1:0]     vector_w;
   logic [DW-1:0]     rd_mux;
   logic [DW-1:0]     rdata_q;

   if (HI_W > 0) begin : g_hi
      assign in_map = (reg_addr[ADDR_W-1:MAP_IDX_W] == '0);
   end else begin : g_nohi
      assign in_map = 1'b1;
   end
   assign idx = ivc_reg_e'(reg_addr[MAP_IDX_W-1:0]);

   ivc_input_cond #(
      .NSRC(NSRC), .EDGE_MASK(EDGE_MASK), .SYNC_STAGES(SYNC_STAGES)
   ) u_cond (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .hit(hit_w)
   );

   ivc_regs #(.NSRC(NSRC)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr & in_map),
      .wr_idx   (idx),
      .wr_bits  (reg_wdata[NSRC-1:0]),
      .wr_ctrl  (reg_wdata[CTRL_W-1:0]),
      .hit      (hit_w),
      .status_q (status_w),
      .enable_q (enable_w),
      .ctrl_q   (ctrl_w)
   );

   assign pend_w = status_w & enable_w;

   ivc_lowest #(.N(NSRC), .DW(DW)) u_low (
      .vec(pend_w), .found(any_pend), .idx(vector_w)
   );

   assign irq_out = ctrl_w[CTRL_OUT_EN] & any_pend;

   always_comb begin
      rd_mux = '0;
      if (in_map) begin
         unique case (idx)
            REG_STATUS: rd_mux[NSRC-1:0]   = status_w;
            REG_PEND:   rd_mux[NSRC-1:0]   = pend_w;
            REG_ENA:    rd_mux[NSRC-1:0]   = enable_w;
            REG_VEC:    rd_mux             = vector_w;
            REG_CTRL:   rd_mux[CTRL_W-1:0] = ctrl_w;
            default:    rd_mux             = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (reg_rd) rdata_q <= rd_mux;
   end

   assign reg_rdata = rdata_q;

endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk
   import ivc_pkg::*;
#(
   parameter int NSRC   = 32,
   parameter int DW     = 32,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DW-1:0]     reg_wdata,
   input logic [NSRC-1:0]   status_w,
   input logic [NSRC-1:0]   enable_w,
   input logic [CTRL_W-1:0] ctrl_w,
   input logic              irq_out,
   input logic [DW-1:0]     vector_w
);

   logic wr_status, wr_ack, wr_set, wr_clr, wr_ctrl;
   assign wr_status = reg_wr && reg_addr == ADDR_W'(REG_STATUS);
   assign wr_ack    = reg_wr && reg_addr == ADDR_W'(REG_ACK);
   assign wr_set    = reg_wr && reg_addr == ADDR_W'(REG_SETEN);
   assign wr_clr    = reg_wr && reg_addr == ADDR_W'(REG_CLREN);
   assign wr_ctrl   = reg_wr && reg_addr == ADDR_W'(REG_CTRL);

   // R3
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ack && !ctrl_w[CTRL_CAP_EN] |=> (status_w & $past(reg_wdata[NSRC-1:0])) == '0);

   // R4
   set_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> (enable_w & $past(reg_wdata[NSRC-1:0])) == $past(reg_wdata[NSRC-1:0]));

   // R5
   clr_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> (enable_w & $past(reg_wdata[NSRC-1:0])) == '0);

   // R7
   status_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_status && ctrl_w[CTRL_CAP_EN] |=> (status_w & $past(status_w)) == $past(status_w));

   // R9
   no_capture_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_w[CTRL_CAP_EN] && !wr_status && !wr_ack |=> $stable(status_w));

   // R12
   out_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl && !reg_wdata[CTRL_OUT_EN] |=> !irq_out);

   // R11
   vector_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> vector_w != '1);

endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.NSRC(NSRC), .DW(DW), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .status_w(status_w), .enable_w(enable_w),
   .ctrl_w(ctrl_w), .irq_out(irq_out), .vector_w(vector_w)
);

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NROW = 26;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] src_in = '0;
   logic        irq_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_vec_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .src_in(src_in), .irq_out(irq_out)
   );

   // row: {is_read, index, data or expected read, expected irq_out}
   localparam logic [37:0] TBL [NROW] = '{
      {1'b0, 4'd2, 32'h0000_00F0, 1'b0},
      {1'b1, 4'd2, 32'h0000_00F0, 1'b0},   // R2 enable readback
      {1'b0, 4'd4, 32'h0000_000F, 1'b0},
      {1'b1, 4'd2, 32'h0000_00FF, 1'b0},   // R4
      {1'b0, 4'd5, 32'h0000_0030, 1'b0},
      {1'b1, 4'd2, 32'h0000_00CF, 1'b0},   // R5
      {1'b0, 4'd0, 32'h0000_0024, 1'b0},
      {1'b1, 4'd0, 32'h0000_0024, 1'b0},   // R7 direct load
      {1'b1, 4'd1, 32'h0000_0004, 1'b0},   // R10
      {1'b1, 4'd6, 32'h0000_0002, 1'b0},   // R11
      {1'b0, 4'd7, 32'hFFFF_FFFD, 1'b0},
      {1'b1, 4'd7, 32'h0000_0001, 1'b1},   // R6, R12
      {1'b0, 4'd1, 32'hFFFF_FFFF, 1'b0},
      {1'b1, 4'd1, 32'h0000_0004, 1'b1},   // R2 pending write ignored
      {1'b0, 4'd6, 32'h0000_0000, 1'b0},
      {1'b1, 4'd6, 32'h0000_0002, 1'b1},   // R2 vector write ignored
      {1'b0, 4'd3, 32'h0000_0004, 1'b0},
      {1'b1, 4'd0, 32'h0000_0020, 1'b0},   // R3
      {1'b1, 4'd6, 32'hFFFF_FFFF, 1'b0},   // R11 nothing pending
      {1'b1, 4'd3, 32'h0000_0000, 1'b0},   // R2 alias reads zero
      {1'b0, 4'd9, 32'hFFFF_FFFF, 1'b0},
      {1'b1, 4'd9, 32'h0000_0000, 1'b0},   // R2 outside map
      {1'b0, 4'd4, 32'h0000_0020, 1'b0},
      {1'b1, 4'd6, 32'h0000_0005, 1'b1},   // R11, R12
      {1'b0, 4'd7, 32'h0000_0000, 1'b0},
      {1'b1, 4'd1, 32'h0000_0020, 1'b0}    // R12 gated off, R13
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      waitc(3);
      rst_n = 1'b1;
      waitc(1);

      // R1 reset state
      check("R1 irq", {31'd0, irq_out}, 32'd0);
      rd(4'd0, v); check("R1 status", v, 32'h0);
      rd(4'd2, v); check("R1 enable", v, 32'h0);
      rd(4'd7, v); check("R1 control", v, 32'h0);
      rd(4'd6, v); check("R1 vector", v, 32'hFFFF_FFFF);

      // table walk, capture off, lines idle; R13 readback after write
      for (int i = 0; i < NROW; i++) begin
         if (TBL[i][37]) begin
            rd(TBL[i][36:33], v);
            check($sformatf("R13 row%0d data", i), v, TBL[i][32:1]);
            check($sformatf("R12 row%0d irq", i), {31'd0, irq_out}, {31'd0, TBL[i][0]});
         end else begin
            wr(TBL[i][36:33], TBL[i][32:1]);
         end
      end

      // fresh state
      @(negedge clk); rst_n = 1'b0;
      waitc(2); rst_n = 1'b1; waitc(1);

      wr(4'd7, 32'h3);
      wr(4'd4, 32'hFFFF_FFFF);

      // R8 level line 3
      src_in[3] = 1'b1;
      waitc(2);
      check("R8 not before third edge", {31'd0, irq_out}, 32'd0);
      waitc(1);
      check("R8 irq after capture", {31'd0, irq_out}, 32'd1);
      rd(4'd0, v); check("R8 status", v, 32'h0000_0008);
      wr(4'd3, 32'h8);
      rd(4'd0, v); check("R8 ack while high", v, 32'h0000_0008);
      src_in[3] = 1'b0;
      waitc(4);
      wr(4'd3, 32'h8);
      rd(4'd0, v); check("R8 ack after low", v, 32'h0);

      // R7 status write blocked
      wr(4'd0, 32'h0000_FFFF);
      rd(4'd0, v); check("R7 blocked", v, 32'h0);

      // R9 edge line 20
      src_in[20] = 1'b1;
      waitc(4);
      rd(4'd0, v); check("R9 edge set", v, 32'h0010_0000);
      rd(4'd6, v); check("R11 vector 20", v, 32'd20);
      wr(4'd3, 32'h0010_0000);
      waitc(6);
      rd(4'd0, v); check("R9 held high no reset", v, 32'h0);
      src_in[20] = 1'b0;

      // R9 edge lost with capture off
      wr(4'd7, 32'h1);
      src_in[21] = 1'b1;
      waitc(5);
      wr(4'd7, 32'h3);
      waitc(4);
      rd(4'd0, v); check("R9 edge lost", v, 32'h0);
      src_in[21] = 1'b0;

      // R11 lowest wins, R10 pending mask
      src_in[7] = 1'b1; src_in[2] = 1'b1;
      waitc(4);
      rd(4'd6, v); check("R11 lowest", v, 32'd2);
      rd(4'd1, v); check("R10 pending", v, 32'h0000_0084);
      wr(4'd5, 32'h4);
      rd(4'd6, v); check("R10 masked vector", v, 32'd7);
      wr(4'd7, 32'h2);
      waitc(1);
      check("R12 output gated", {31'd0, irq_out}, 32'd0);
      src_in = '0;
      waitc(2);

      finish_run();
   end

endmodule